// File: doc/BRIEF.md
# Dual-Port PS/2 Host Register Interface

This block sits between a simple synchronous register bus and two PS/2 device channels. Channel 0 serves a keyboard and channel 1 a mouse. Each channel has its own 256-byte register window, picked by a port-select input. Only address bits [3:2] choose a register inside the window. The block does not serialise PS/2 clock and data. It works with whole bytes. When the host writes a transmit byte, the block raises a one-cycle strobe toward the device side. Bytes from the device arrive on a valid/ready stream, wait in a 16-entry receive FIFO, and are taken out by host reads.

Each channel has two test aids. In loopback mode the transmit register becomes a one-byte mailbox: a write fills it, and the next receive read empties it. Its flag and interrupt are separate from the FIFO's. In diagnostic mode the two line-state bits in status follow the direction bits in control. A single interrupt line serves both channels. Each channel's status word also shows whether either channel is requesting service.

Top module: `ps2_dual_host`

## Requirements
- R1: After reset, control reads 0x00 on both ports, `irq` is low, every `devRxReady` is high, no transmit strobe is active, and status reads 0xC0.
- R2: Offset 0 reads 0 on port 0 and 1 on port 1. A write to offset 0 changes nothing that can be read back.
- R3: With control bit 1 (loopback) clear, a write to offset 4 makes that port's `devTxValid` high for exactly the next cycle, with the written low byte on `devTxData`. The other port's strobe stays low.
- R4: A byte on `devRxData` with `devRxValid` and `devRxReady` both high is stored. Reads at offset 4 return stored bytes oldest first and pop them. Status bit 0 is 1 while the FIFO holds data.
- R5: A port holds at most 16 received bytes. While it is full, `devRxReady` is low and incoming bytes are dropped.
- R6: A receive read of an empty FIFO returns the byte most recently popped (0 if none has been popped), and nothing is removed.
- R7: With loopback set, a write to offset 4 stores the byte and sets both status bit 0 and the port interrupt, with no transmit strobe. The next read at offset 4 returns the byte and clears both.
- R8: Status bits 6 (data line) and 7 (clock line) read 1. While control bit 5 (diagnostic) is set, bit 6 reads control bit 6 and bit 7 reads control bit 7.
- R9: A port's interrupt is its loopback flag in loopback mode and its FIFO-not-empty level otherwise. `irq` is the OR of both ports' interrupts. Status bit 4 on both ports reads the same value as `irq`.
- R10: Control keeps bits [7:0] of the write data. Read data bits [31:8] are 0. Status bits 1, 2, 3 and 5 read 0. Writes to offset 12 have no effect. When neither read nor write is active, read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Port select: 0 keyboard, 1 mouse |
| busAddr | input | 8 | Byte address inside the port window; bits [3:2] decoded |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe; a receive read pops at the clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid in the cycle of `busRdEn` |
| devRxData | input | 2x8 | Received byte per port |
| devRxValid | input | 2 | Received byte present, per port |
| devRxReady | output | 2 | FIFO can take a byte, per port |
| devTxData | output | 2x8 | Byte to send, per port |
| devTxValid | output | 2 | One-cycle transmit strobe, per port |
| irq | output | 1 | Shared interrupt |

## Verification
The assertions assume that `busRdEn` and `busWrEn` are never high in the same cycle. They also assume that the reset is held long enough for every register to clear before the bus becomes active. The stimulus issues exactly one bus operation per cycle and drives both enables low while reset is held. Device bytes are offered whether or not the FIFO is ready. The bench therefore drives the full-FIFO drop path on purpose, and it drives a push in the same cycle as a pop.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
  typedef enum logic [1:0] {
    OFF_ID   = 2'd0,
    OFF_DATA = 2'd1,
    OFF_CTRL = 2'd2,
    OFF_STAT = 2'd3
  } regOff_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrTx;
    logic rdRx;
  } portStrobe_t;

  localparam int CTL_LOOP = 1;
  localparam int CTL_DIAG = 5;
  localparam int CTL_DDIR = 6;
  localparam int CTL_CDIR = 7;
endpackage

// File: rtl/ps2h_ctrl.sv
module ps2h_ctrl
  import ps2h_pkg::*;
#(
  parameter int NPORTS = 2,
  localparam int SEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  busSel,
  input  logic [7:0]        busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regOff_e           regOff,
  output portStrobe_t       strobe [NPORTS]
);
  logic unusedAddr;
  assign unusedAddr = ^{busAddr[7:4], busAddr[1:0]};
  assign regOff = regOff_e'(busAddr[3:2]);

  for (genvar p = 0; p < NPORTS; p++) begin : g_strobe
    logic hit;
    assign hit = (busSel == SEL_W'(p));
    assign strobe[p].wrCtrl = hit && busWrEn && (regOff == OFF_CTRL);
    assign strobe[p].wrTx   = hit && busWrEn && (regOff == OFF_DATA);
    assign strobe[p].rdRx   = hit && busRdEn && (regOff == OFF_DATA);

    // one register action per port per cycle
    assert_single_action_R10: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({strobe[p].wrCtrl, strobe[p].wrTx, strobe[p].rdRx}));
  end
endmodule

// File: rtl/ps2h_port.sv
module ps2h_port
  import ps2h_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int PORT_ID = 0,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  portStrobe_t strobe,
  input  regOff_e     regOff,
  input  logic [7:0]  wrByte,
  input  logic        anyIrq,
  input  logic [7:0]  rxData,
  input  logic        rxValid,
  output logic        rxReady,
  output logic [7:0]  txData,
  output logic        txValid,
  output logic        portIrq,
  output logic [7:0]  rdByte
);
  logic [7:0] ctrlReg, lbByte, lastRd;
  logic       lbFull;
  logic [7:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  logic loopMode, fifoEmpty, fifoFull, doPush, doPop;
  assign loopMode  = ctrlReg[CTL_LOOP];
  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign doPush    = rxValid && !fifoFull;
  assign doPop     = strobe.rdRx && !loopMode && !fifoEmpty;
  assign rxReady   = !fifoFull;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] ptr);
    return (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= rxData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      lbByte  <= '0;
      lbFull  <= 1'b0;
      lastRd  <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      txData  <= '0;
      txValid <= 1'b0;
    end else begin
      if (strobe.wrCtrl) ctrlReg <= wrByte;
      txValid <= strobe.wrTx && !loopMode;
      if (strobe.wrTx && !loopMode) txData <= wrByte;
      if (strobe.wrTx && loopMode) begin
        lbByte <= wrByte;
        lbFull <= 1'b1;
      end else if (strobe.rdRx && loopMode) begin
        lbFull <= 1'b0;
      end
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop) begin
        rdPtr  <= bump(rdPtr);
        lastRd <= mem[rdPtr];
      end
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign portIrq = loopMode ? lbFull : !fifoEmpty;

  logic [7:0] status;
  always_comb begin
    status = 8'hC0;
    if (ctrlReg[CTL_DIAG]) begin
      status[6] = ctrlReg[CTL_DDIR];
      status[7] = ctrlReg[CTL_CDIR];
    end
    status[0] = loopMode ? lbFull : !fifoEmpty;
    status[4] = anyIrq;
  end

  always_comb begin
    case (regOff)
      OFF_ID:   rdByte = 8'(PORT_ID);
      OFF_DATA: rdByte = loopMode ? lbByte : (fifoEmpty ? lastRd : mem[rdPtr]);
      OFF_CTRL: rdByte = ctrlReg;
      default:  rdByte = status;
    endcase
  end

  assert_count_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !strobe.rdRx) |=> fifoFull);
  assert_tx_after_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(strobe.wrTx));
  assert_loop_no_tx_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrTx && loopMode) |=> !txValid);
  assert_loop_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdRx && loopMode) |=> !lbFull);
endmodule

// File: rtl/ps2_dual_host.sv
module ps2_dual_host
  import ps2h_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busSel,
  input  logic [7:0]      busAddr,
  input  logic            busWrEn,
  input  logic            busRdEn,
  input  logic [31:0]     busWrData,
  output logic [31:0]     busRdData,
  input  logic [1:0][7:0] devRxData,
  input  logic [1:0]      devRxValid,
  output logic [1:0]      devRxReady,
  output logic [1:0][7:0] devTxData,
  output logic [1:0]      devTxValid,
  output logic            irq
);
  localparam int NPORTS = 2;

  regOff_e     regOff;
  portStrobe_t strobe [NPORTS];
  logic [NPORTS-1:0] portIrq;
  logic [7:0]  portRd [NPORTS];

  logic unusedData;
  assign unusedData = ^busWrData[31:8];

  ps2h_ctrl #(.NPORTS(NPORTS)) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .regOff(regOff), .strobe(strobe)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    ps2h_port #(.DEPTH(FIFO_DEPTH), .PORT_ID(p)) i_port (
      .clk(clk), .rstN(rstN), .strobe(strobe[p]), .regOff(regOff),
      .wrByte(busWrData[7:0]), .anyIrq(irq),
      .rxData(devRxData[p]), .rxValid(devRxValid[p]), .rxReady(devRxReady[p]),
      .txData(devTxData[p]), .txValid(devTxValid[p]),
      .portIrq(portIrq[p]), .rdByte(portRd[p])
    );
  end

  assign irq       = |portIrq;
  assign busRdData = busRdEn ? {24'h0, portRd[busSel]} : 32'h0;

  assert_tx_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(devTxValid[0] && devTxValid[1]));
endmodule

// File: tb/test_ps2_dual_host.sv
module test_ps2_dual_host;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 1'b0, busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic [1:0][7:0] devRxData = '0, devTxData;
  logic [1:0] devRxValid = '0, devRxReady, devTxValid;
  logic irq;

  ps2_dual_host i_ps2_dual_host (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData),
    .busRdData(busRdData), .devRxData(devRxData), .devRxValid(devRxValid),
    .devRxReady(devRxReady), .devTxData(devTxData), .devTxValid(devTxValid),
    .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] mCtrl [2], mLast [2], mLbB [2], mTxB [2];
  logic mLbF [2], mTxV [2];
  logic [7:0] q0 [$], q1 [$];

  function automatic int qSize(input int p);
    return (p == 0) ? q0.size() : q1.size();
  endfunction
  function automatic logic [7:0] qFront(input int p);
    return (p == 0) ? q0[0] : q1[0];
  endfunction
  function automatic logic mIrqP(input int p);
    return mCtrl[p][1] ? mLbF[p] : (qSize(p) > 0);
  endfunction
  function automatic logic [31:0] mRead(input int p, input logic [1:0] off);
    logic [7:0] st;
    case (off)
      2'd0: return 32'(p);
      2'd1: return mCtrl[p][1] ? {24'h0, mLbB[p]}
                 : {24'h0, (qSize(p) > 0) ? qFront(p) : mLast[p]};
      2'd2: return {24'h0, mCtrl[p]};
      default: begin
        st = 8'hC0;
        if (mCtrl[p][5]) begin
          if (!mCtrl[p][6]) st[6] = 1'b0;
          if (!mCtrl[p][7]) st[7] = 1'b0;
        end
        st[0] = mCtrl[p][1] ? mLbF[p] : (qSize(p) > 0);
        st[4] = mIrqP(0) | mIrqP(1);
        return {24'h0, st};
      end
    endcase
  endfunction

  task automatic bad(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    miscompares++;
    $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
  endtask

  task automatic step(input string tag, input int sel, input logic wr, input logic rd,
                      input logic [1:0] off, input logic [31:0] data,
                      input logic [1:0] rv, input logic [7:0] d0, input logic [7:0] d1);
    int pre [2];
    logic [31:0] expRd;
    @(negedge clk);
    busSel = sel[0]; busWrEn = wr; busRdEn = rd;
    busAddr = {4'h5, off, 2'b01};
    busWrData = data; devRxValid = rv; devRxData[0] = d0; devRxData[1] = d1;
    #1;
    vectors++;
    expRd = rd ? mRead(sel, off) : 32'h0;
    if (busRdData !== expRd) bad(tag, "busRdData", busRdData, expRd);
    if (irq !== (mIrqP(0) | mIrqP(1))) bad(tag, "irq", 32'(irq), 32'(mIrqP(0) | mIrqP(1)));
    for (int p = 0; p < 2; p++) begin
      if (devRxReady[p] !== (qSize(p) < 16)) bad(tag, "devRxReady", 32'(devRxReady[p]), 32'(qSize(p) < 16));
      if (devTxValid[p] !== mTxV[p]) bad(tag, "devTxValid", 32'(devTxValid[p]), 32'(mTxV[p]));
      else if (mTxV[p] && devTxData[p] !== mTxB[p]) bad(tag, "devTxData", 32'(devTxData[p]), 32'(mTxB[p]));
    end
    @(posedge clk);
    pre[0] = qSize(0); pre[1] = qSize(1);
    if (rd && off == 2'd1) begin
      if (mCtrl[sel][1]) mLbF[sel] = 1'b0;
      else if (pre[sel] > 0) mLast[sel] = (sel == 0) ? q0.pop_front() : q1.pop_front();
    end
    if (rv[0] && pre[0] < 16) q0.push_back(d0);
    if (rv[1] && pre[1] < 16) q1.push_back(d1);
    mTxV[0] = 1'b0; mTxV[1] = 1'b0;
    if (wr && off == 2'd1) begin
      if (mCtrl[sel][1]) begin mLbB[sel] = data[7:0]; mLbF[sel] = 1'b1; end
      else begin mTxV[sel] = 1'b1; mTxB[sel] = data[7:0]; end
    end
    if (wr && off == 2'd2) mCtrl[sel] = data[7:0];
  endtask

  task automatic rdOp(input string tag, input int sel, input logic [1:0] off);
    step(tag, sel, 1'b0, 1'b1, off, 32'h0, 2'b00, 8'h0, 8'h0);
  endtask
  task automatic wrOp(input string tag, input int sel, input logic [1:0] off, input logic [31:0] d);
    step(tag, sel, 1'b1, 1'b0, off, d, 2'b00, 8'h0, 8'h0);
  endtask
  task automatic idle(input string tag);
    step(tag, 0, 1'b0, 1'b0, 2'd0, 32'h0, 2'b00, 8'h0, 8'h0);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      mCtrl[p] = '0; mLast[p] = '0; mLbB[p] = '0; mTxB[p] = '0;
      mLbF[p] = 1'b0; mTxV[p] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    idle("R1");
    rdOp("R1", 0, 2'd3); rdOp("R1", 1, 2'd3);
    rdOp("R1", 0, 2'd2); rdOp("R1", 1, 2'd2);
    // R2 identity and inert reset register
    rdOp("R2", 0, 2'd0); rdOp("R2", 1, 2'd0);
    wrOp("R2", 0, 2'd0, 32'hFFFF_FFFF); wrOp("R2", 1, 2'd0, 32'h0000_00A7);
    rdOp("R2", 0, 2'd2); rdOp("R2", 1, 2'd3); rdOp("R2", 1, 2'd0);
    // R3 transmit strobes
    wrOp("R3", 0, 2'd1, 32'h1234_565A); idle("R3");
    wrOp("R3", 1, 2'd1, 32'h0000_00A5); wrOp("R3", 1, 2'd1, 32'h0000_00C3);
    wrOp("R3", 0, 2'd1, 32'h0000_0011); idle("R3");
    // R4 FIFO order, status, irq
    step("R4", 0, 1'b0, 1'b0, 2'd0, 0, 2'b01, 8'h21, 8'h0);
    step("R4", 0, 1'b0, 1'b0, 2'd0, 0, 2'b01, 8'h22, 8'h0);
    step("R4", 0, 1'b0, 1'b1, 2'd3, 0, 2'b01, 8'h23, 8'h0);
    rdOp("R9", 1, 2'd3);
    rdOp("R4", 0, 2'd1);
    step("R4", 0, 1'b0, 1'b1, 2'd1, 0, 2'b01, 8'h24, 8'h0);
    rdOp("R4", 0, 2'd1); rdOp("R4", 0, 2'd1);
    // R6 empty reads repeat the last byte
    rdOp("R6", 0, 2'd1); rdOp("R6", 0, 2'd1); rdOp("R6", 0, 2'd3);
    rdOp("R6", 1, 2'd1);
    // R5 fill port 1 past capacity
    for (int i = 0; i < 18; i++)
      step("R5", 0, 1'b0, 1'b0, 2'd0, 0, 2'b10, 8'h0, 8'(8'h40 + i));
    step("R5", 1, 1'b0, 1'b1, 2'd1, 0, 2'b10, 8'h0, 8'h80);
    step("R5", 1, 1'b0, 1'b0, 2'd0, 0, 2'b10, 8'h0, 8'h81);
    for (int i = 0; i < 17; i++) rdOp("R5", 1, 2'd1);
    // R7 loopback mailbox
    wrOp("R7", 0, 2'd2, 32'h0000_0003);
    rdOp("R7", 0, 2'd3);
    wrOp("R7", 0, 2'd1, 32'h0000_003C);
    rdOp("R7", 0, 2'd3); rdOp("R9", 1, 2'd3);
    step("R7", 0, 1'b0, 1'b1, 2'd1, 0, 2'b01, 8'h77, 8'h0);
    rdOp("R7", 0, 2'd3); idle("R7");
    wrOp("R7", 0, 2'd2, 32'h0000_0001);
    rdOp("R7", 0, 2'd3); rdOp("R7", 0, 2'd1); rdOp("R7", 0, 2'd3);
    // R8 diagnostic line bits
    wrOp("R8", 1, 2'd2, 32'h0000_0020); rdOp("R8", 1, 2'd3);
    wrOp("R8", 1, 2'd2, 32'h0000_0060); rdOp("R8", 1, 2'd3);
    wrOp("R8", 1, 2'd2, 32'h0000_00A0); rdOp("R8", 1, 2'd3);
    wrOp("R8", 1, 2'd2, 32'h0000_00E0); rdOp("R8", 1, 2'd3);
    wrOp("R8", 1, 2'd2, 32'h0000_0040); rdOp("R8", 1, 2'd3);
    // R9 shared interrupt from either port
    step("R9", 0, 1'b0, 1'b0, 2'd0, 0, 2'b10, 8'h0, 8'h99);
    rdOp("R9", 0, 2'd3); rdOp("R9", 1, 2'd3);
    rdOp("R9", 1, 2'd1); rdOp("R9", 0, 2'd3);
    // R10 control width, offset 12 writes, reserved bits
    wrOp("R10", 0, 2'd2, 32'hFFFF_FF81); rdOp("R10", 0, 2'd2);
    wrOp("R10", 0, 2'd3, 32'hFFFF_FFFF); rdOp("R10", 0, 2'd2);
    rdOp("R10", 0, 2'd3); idle("R10");
    wrOp("R10", 0, 2'd1, 32'hABCD_EF12); idle("R10");

    finished = 1;
    report();
    $finish;
  end
endmodule